// File: doc/BRIEF.md
# Three-wire serial EEPROM device controller

This block is the device side of a three-wire serial memory. It has a chip select, a serial clock, a data input and a data output, and an organisation input that picks 8-bit bytes or 16-bit words. The serial pins are synchronised into the system clock domain and edge-detected. A small register-array memory sits behind an instruction decoder. The decoder waits for a start bit, takes a two-bit opcode and an address, and then reads, programs, erases, fills or changes the programming enable. Data-out carries an output-enable that models the high-impedance state of the pin.

Programming is self-timed. The cycle starts on the falling edge of chip select, but only if the instruction had exactly the number of clock pulses it requires. A counter in system clock cycles then models the programming time. While that counter runs, the data pin reports busy, and ready once the cycle has finished. Reads output one leading zero bit and then stream words continuously, with the address advancing on its own and wrapping at the top of the array.

Top module: `mw_eeprom`

## Requirements
- R1: After chip select rises, data-in bits sampled as 0 on rising serial-clock edges are skipped. The first 1 is the start bit.
- R2: The two bits after the start bit form the opcode, in these encodings: 10 read, 01 write, 11 erase. For opcode 00 the two most significant address bits choose the operation: 11 enable programming, 00 disable programming, 10 erase-all, 01 write-all. The rest of the address is ignored.
- R3: With org16_i high, the array holds 16-bit words with ADDR_W address bits. With org16_i low, it holds bytes with ADDR_W+1 address bits. Byte b is the upper half of word b>>1 when b[0]=1 and the lower half when b[0]=0. Address and data are sent MSB first.
- R4: A read drives a dummy 0 after the last address bit and then the data MSB first. Each output bit changes on a rising serial-clock edge.
- R5: While chip select stays high, a read continues with the next address and no dummy bit between words. After the highest address it wraps to address 0.
- R6: A write, erase, erase-all or write-all is carried out only if chip select falls after the last required bit and before any further rising clock edge. With one pulse too few or too many, the memory is left unchanged.
- R7: Erase sets the addressed location to all ones. Write stores exactly the data sent. Write-all stores the data at every location. Erase-all sets every bit to one.
- R8: Programming is disabled after reset. Once enabled it stays enabled until a disable instruction. While disabled, programming instructions leave the memory unchanged. Reads work in either state.
- R9: While a programming cycle runs, data-out is 0 whenever chip select is high, and all serial input is ignored. When the cycle ends with chip select high, data-out is 1 until a start bit arrives or chip select falls.
- R10: dout_oe_o is low whenever synchronised chip select is low. At reset every memory bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_i | input | 1 | Chip select, active high, asynchronous to clk |
| sck_i | input | 1 | Serial clock, asynchronous to clk |
| din_i | input | 1 | Serial data in |
| org16_i | input | 1 | Organisation: 1 selects 16-bit words, 0 selects bytes; held static during an instruction |
| dout_o | output | 1 | Serial data out and busy/ready status |
| dout_oe_o | output | 1 | Output enable for dout_o |

## Verification
The bench targets the pulse-count window. One write gets an extra clock before chip select falls and another is one data bit short. A decoder that accepted a shifted frame would corrupt a location, and one that counted pulses wrongly would reject good writes. Reads run across a word boundary and across the top of the array. A design that re-emitted the dummy bit or failed to wrap would shift or misalign the stream. Busy is checked while clocks are applied during programming, where a design that did not ignore input would decode a new instruction. The byte-to-word mapping is checked by writing a byte and reading the enclosing word, and the enable gate is checked both before the first enable and after a disable.

// File: rtl/mw_pkg.sv
// Shared types for the serial EEPROM controller.
// Assumes: nothing beyond IEEE 1800-2017.
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // chip select low
        ST_HUNT,   // selected, waiting for start bit
        ST_SHIFT,  // collecting opcode, address, data
        ST_READ,   // streaming read data
        ST_WAITF,  // frame complete, waiting for select fall
        ST_DONE,   // instruction finished or rejected
        ST_BUSY    // self-timed programming cycle
    } mw_state_t;

    typedef enum logic [2:0] {
        OP_NONE, OP_READ, OP_WRITE, OP_ERASE,
        OP_EWEN, OP_EWDS, OP_ERAL, OP_WRAL
    } mw_op_t;

endpackage

// File: rtl/mw_sync.sv
// Multi-stage synchroniser for one asynchronous input.
// Produces the synchronised level and its one-cycle-delayed copy for edge detection.
// Assumes: STAGES >= 2.
module mw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic a_i,
    output logic s_o,
    output logic prev_o
);
    logic [STAGES:0] pipe;

    // shift the input through the synchroniser chain plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], a_i};
    end

    assign s_o    = pipe[STAGES-1];
    assign prev_o = pipe[STAGES];
endmodule

// File: rtl/mw_mem.sv
// Register-array storage of 2**AW 16-bit words, with byte or word access.
// Byte address b is the upper half of word b>>1 when b[0]=1.
// Assumes: writes are single-cycle pulses; the array resets to all ones.
module mw_mem #(
    parameter int AW = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        org16_i,
    input  logic [AW:0] rd_addr_i,
    output logic [15:0] rd_word_o,
    input  logic        wr_en_i,
    input  logic        wr_all_i,
    input  logic [AW:0] wr_addr_i,
    input  logic [15:0] wr_data_i
);
    localparam int DEPTH = 2 ** AW;

    logic [15:0] mem [DEPTH];
    logic [15:0] fill;

    // word pattern used by a whole-array fill
    assign fill = org16_i ? wr_data_i : {wr_data_i[7:0], wr_data_i[7:0]};

    // array update: reset to ones, single location or whole-array write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr_en_i) begin
            if (wr_all_i) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= fill;
            end else if (org16_i) begin
                mem[wr_addr_i[AW-1:0]] <= wr_data_i;
            end else if (wr_addr_i[0]) begin
                mem[wr_addr_i[AW:1]][15:8] <= wr_data_i[7:0];
            end else begin
                mem[wr_addr_i[AW:1]][7:0] <= wr_data_i[7:0];
            end
        end
    end

    // read selection: full word, or the addressed byte in the low half
    always_comb begin
        if (org16_i)           rd_word_o = mem[rd_addr_i[AW-1:0]];
        else if (rd_addr_i[0]) rd_word_o = {8'h00, mem[rd_addr_i[AW:1]][15:8]};
        else                   rd_word_o = {8'h00, mem[rd_addr_i[AW:1]][7:0]};
    end

    // R7: a word-mode fill reaches both ends of the array
    a_r7_fill_reaches_all: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_all_i && org16_i) |=>
            (mem[0] == $past(wr_data_i) && mem[DEPTH-1] == $past(wr_data_i)));
endmodule

// File: rtl/mw_ctrl.sv
// Instruction decoder and sequencer for the serial EEPROM.
// Works on synchronised, edge-detected serial signals; one sck_rise_i per serial clock.
// Assumes: org16_i is static during an instruction; AW >= 2.
module mw_ctrl
    import mw_pkg::*;
#(
    parameter int AW          = 4,
    parameter int PROG_CYCLES = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_s_i,
    input  logic        sel_rise_i,
    input  logic        sel_fall_i,
    input  logic        sck_rise_i,
    input  logic        din_i,
    input  logic        org16_i,
    output logic        dout_o,
    output logic [AW:0] rd_addr_o,
    input  logic [15:0] rd_word_i,
    output logic        wr_en_o,
    output logic        wr_all_o,
    output logic [AW:0] wr_addr_o,
    output logic [15:0] wr_data_o
);
    localparam int BCW = $clog2(AW + 20);
    localparam int PCW = $clog2(PROG_CYCLES + 1);

    mw_state_t      state;
    mw_op_t         op_q, dec_op;
    logic [BCW-1:0] bcnt, alen, dlen;
    logic [AW:0]    addr_q, nxt_addr, addr_inc;
    logic [15:0]    data_q;
    logic [1:0]     hdr_q, top2;
    logic [3:0]     idx, bit_sel;
    logic [PCW-1:0] busy_cnt;
    logic           wen_q, rdy_q, dout_q, prog_go, hdr_end, data_end;

    // frame geometry for the current organisation
    assign alen     = org16_i ? BCW'(AW) : BCW'(AW + 1);
    assign dlen     = org16_i ? BCW'(16) : BCW'(8);
    assign nxt_addr = {addr_q[AW-1:0], din_i};
    assign top2     = org16_i ? nxt_addr[AW-1:AW-2] : nxt_addr[AW:AW-1];
    assign hdr_end  = (bcnt == BCW'(1) + alen);
    assign data_end = (bcnt == BCW'(1) + alen + dlen);
    assign bit_sel  = 4'(dlen - BCW'(1)) - idx;
    assign addr_inc = org16_i ? {1'b0, addr_q[AW-1:0] + 1'b1} : addr_q + 1'b1;

    // opcode decode, including the extended codes in the top address bits
    always_comb begin
        unique case (hdr_q)
            2'b10:   dec_op = OP_READ;
            2'b01:   dec_op = OP_WRITE;
            2'b11:   dec_op = OP_ERASE;
            default: begin
                unique case (top2)
                    2'b11:   dec_op = OP_EWEN;
                    2'b00:   dec_op = OP_EWDS;
                    2'b10:   dec_op = OP_ERAL;
                    default: dec_op = OP_WRAL;
                endcase
            end
        endcase
    end

    assign prog_go   = (state == ST_WAITF) && sel_fall_i;
    assign wr_en_o   = prog_go;
    assign wr_all_o  = (op_q == OP_ERAL) || (op_q == OP_WRAL);
    assign wr_addr_o = addr_q;
    assign wr_data_o = ((op_q == OP_ERASE) || (op_q == OP_ERAL)) ? '1 : data_q;
    assign rd_addr_o = addr_q;

    // output mux: busy low, ready high, otherwise the read shifter
    assign dout_o = (state == ST_BUSY) ? 1'b0 : (rdy_q ? 1'b1 : dout_q);

    // main sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            op_q     <= OP_NONE;
            bcnt     <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            hdr_q    <= '0;
            idx      <= '0;
            busy_cnt <= '0;
            wen_q    <= 1'b0;
            rdy_q    <= 1'b0;
            dout_q   <= 1'b1;
        end else if (state == ST_BUSY) begin
            if (busy_cnt > PCW'(1)) begin
                busy_cnt <= busy_cnt - 1'b1;
            end else begin
                state <= sel_s_i ? ST_HUNT : ST_IDLE;
                rdy_q <= sel_s_i;
            end
        end else if (prog_go) begin
            state    <= ST_BUSY;
            busy_cnt <= PCW'(PROG_CYCLES);
        end else if (sel_fall_i) begin
            state <= ST_IDLE;
            rdy_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (sel_rise_i) state <= ST_HUNT;
                ST_HUNT: if (sck_rise_i && din_i) begin
                    state  <= ST_SHIFT;
                    rdy_q  <= 1'b0;
                    bcnt   <= '0;
                    addr_q <= '0;
                    data_q <= '0;
                end
                ST_SHIFT: if (sck_rise_i) begin
                    bcnt <= bcnt + 1'b1;
                    if (bcnt < BCW'(2)) begin
                        hdr_q <= {hdr_q[0], din_i};
                    end else if (bcnt <= BCW'(1) + alen) begin
                        addr_q <= nxt_addr;
                        if (hdr_end) begin
                            op_q <= dec_op;
                            unique case (dec_op)
                                OP_READ: begin
                                    state  <= ST_READ;
                                    dout_q <= 1'b0;
                                    idx    <= '0;
                                end
                                OP_EWEN: begin wen_q <= 1'b1; state <= ST_DONE; end
                                OP_EWDS: begin wen_q <= 1'b0; state <= ST_DONE; end
                                OP_ERASE, OP_ERAL: state <= wen_q ? ST_WAITF : ST_DONE;
                                default:           state <= wen_q ? ST_SHIFT : ST_DONE;
                            endcase
                        end
                    end else begin
                        data_q <= {data_q[14:0], din_i};
                        if (data_end) state <= ST_WAITF;
                    end
                end
                ST_READ: if (sck_rise_i) begin
                    dout_q <= rd_word_i[bit_sel];
                    if (idx == 4'(dlen - BCW'(1))) begin
                        idx    <= '0;
                        addr_q <= addr_inc;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_WAITF: if (sck_rise_i) state <= ST_DONE;
                default: ;
            endcase
        end
    end

    // R6: programming is entered only from a complete frame on a select fall
    a_r6_busy_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && $past(state) != ST_BUSY) |->
            ($past(state) == ST_WAITF && $past(sel_fall_i)));

    // R8: a programming cycle never runs while programming is disabled
    a_r8_busy_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY) |-> wen_q);

    // R9: serial activity cannot cut a programming cycle short
    a_r9_stay_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && busy_cnt > PCW'(1)) |=> (state == ST_BUSY));

    // R5: in word mode the streamed address stays inside the word range
    a_r5_word_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && org16_i) |-> (addr_q[AW] == 1'b0));
endmodule

// File: rtl/mw_eeprom.sv
// Top level of the three-wire serial EEPROM device controller.
// Synchronises select, clock and data, then drives the sequencer and the array.
// Assumes: serial clock half-period spans several system clocks; org16_i static.
module mw_eeprom #(
    parameter int ADDR_W      = 4,
    parameter int PROG_CYCLES = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sck_i,
    input  logic din_i,
    input  logic org16_i,
    output logic dout_o,
    output logic dout_oe_o
);
    logic sel_s, sel_p, sck_s, sck_p;
    logic [SYNC_STAGES-1:0] din_pipe;
    logic [ADDR_W:0] rd_addr, wr_addr;
    logic [15:0]     rd_word, wr_data;
    logic            wr_en, wr_all;

    mw_sync #(.STAGES(SYNC_STAGES)) u_sel_sync (
        .clk(clk), .rst_n(rst_n), .a_i(sel_i), .s_o(sel_s), .prev_o(sel_p));

    mw_sync #(.STAGES(SYNC_STAGES)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .a_i(sck_i), .s_o(sck_s), .prev_o(sck_p));

    // data-in chain matched in depth to the clock synchroniser
    always_ff @(posedge clk) begin
        if (!rst_n) din_pipe <= '0;
        else        din_pipe <= {din_pipe[SYNC_STAGES-2:0], din_i};
    end

    mw_ctrl #(.AW(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_s_i    (sel_s),
        .sel_rise_i (sel_s & ~sel_p),
        .sel_fall_i (~sel_s & sel_p),
        .sck_rise_i (sck_s & ~sck_p),
        .din_i      (din_pipe[SYNC_STAGES-1]),
        .org16_i    (org16_i),
        .dout_o     (dout_o),
        .rd_addr_o  (rd_addr),
        .rd_word_i  (rd_word),
        .wr_en_o    (wr_en),
        .wr_all_o   (wr_all),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data)
    );

    mw_mem #(.AW(ADDR_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .org16_i   (org16_i),
        .rd_addr_i (rd_addr),
        .rd_word_o (rd_word),
        .wr_en_i   (wr_en),
        .wr_all_i  (wr_all),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data)
    );

    assign dout_oe_o = sel_s;
endmodule

// File: tb/mw_eeprom_tb.sv
// Scoreboard bench: driver tasks push expected output bits, a monitor pops and compares.
module mw_eeprom_tb;
    localparam int AW   = 4;
    localparam int PROG = 120;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sel = 1'b0, sck = 1'b0, din = 1'b0, org16 = 1'b1;
    logic dout, dout_oe;

    int n_chk = 0, n_fail = 0;
    logic [15:0] model [2**AW];
    logic  exp_q [$];
    string tag_q [$];
    event  smp_ev;

    always #4 clk = ~clk;

    mw_eeprom #(.ADDR_W(AW), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .sck_i(sck), .din_i(din),
        .org16_i(org16), .dout_o(dout), .dout_oe_o(dout_oe));

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compare each sampled output bit against the scoreboard head
    initial begin
        forever begin
            @(smp_ev);
            check(tag_q.pop_front(), {15'd0, dout}, {15'd0, exp_q.pop_front()});
        end
    end

    // reference model, written from R3
    function automatic logic [15:0] mrd(input bit o16, input int a);
        int b;
        if (o16) return model[a % (2**AW)];
        b = a % (2**(AW+1));
        return (b % 2 == 1) ? {8'h00, model[b/2][15:8]} : {8'h00, model[b/2][7:0]};
    endfunction

    function automatic void mwr(input bit o16, input int a, input logic [15:0] d);
        int b;
        if (o16) model[a % (2**AW)] = d;
        else begin
            b = a % (2**(AW+1));
            if (b % 2 == 1) model[b/2][15:8] = d[7:0];
            else            model[b/2][7:0]  = d[7:0];
        end
    endfunction

    function automatic void mall(input bit o16, input logic [15:0] d);
        for (int i = 0; i < 2**AW; i++) model[i] = o16 ? d : {d[7:0], d[7:0]};
    endfunction

    // one serial bit; optionally score dout late in the high phase
    task automatic sbit(input logic b, input bit chk, input logic e, input string tag);
        @(negedge clk) din = b;
        repeat (5) @(negedge clk);
        sck = 1'b1;
        repeat (7) @(negedge clk);
        if (chk) begin
            exp_q.push_back(e);
            tag_q.push_back(tag);
            ->smp_ev;
        end
        sck = 1'b0;
    endtask

    task automatic sel_up();
        @(negedge clk) sel = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic sel_dn();
        @(negedge clk) sel = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // programming-type instruction; adj: -1 one data bit short, +1 one extra clock
    task automatic prog_cmd(input bit o16, input logic [1:0] op, input int addr,
                            input bit wdata, input logic [15:0] d, input int adj,
                            input bit lead0, input bit wait_done);
        int alen = o16 ? AW : AW + 1;
        int dl   = o16 ? 16 : 8;
        int n;
        sel_up();
        if (lead0) begin sbit(1'b0, 0, 1'b0, ""); sbit(1'b0, 0, 1'b0, ""); end
        sbit(1'b1, 0, 1'b0, "");
        sbit(op[1], 0, 1'b0, "");
        sbit(op[0], 0, 1'b0, "");
        for (int i = alen - 1; i >= 0; i--) sbit(addr[i], 0, 1'b0, "");
        if (wdata) begin
            n = (adj < 0) ? dl - 1 : dl;
            for (int k = dl - 1; k >= dl - n; k--) sbit(d[k], 0, 1'b0, "");
        end
        if (adj > 0) sbit(1'b0, 0, 1'b0, "");
        sel_dn();
        if (wait_done) repeat (PROG + 20) @(negedge clk);
    endtask

    // extended instruction selected by the top two address bits (R2)
    task automatic ext_cmd(input bit o16, input logic [1:0] top2, input bit wdata,
                           input logic [15:0] d);
        int alen = o16 ? AW : AW + 1;
        prog_cmd(o16, 2'b00, int'(top2) << (alen - 2), wdata, d, 0, 0, 1);
    endtask

    // read n locations from addr, scoring the dummy bit and every data bit
    task automatic read_seq(input bit o16, input int addr, input int n, input string tag);
        int alen = o16 ? AW : AW + 1;
        int dl   = o16 ? 16 : 8;
        int a    = addr;
        logic [15:0] v;
        sel_up();
        sbit(1'b1, 0, 1'b0, "");
        sbit(1'b1, 0, 1'b0, "");
        sbit(1'b0, 0, 1'b0, "");
        for (int i = alen - 1; i >= 0; i--)
            sbit(addr[i], (i == 0), 1'b0, {tag, " R4 dummy zero"});
        for (int w = 0; w < n; w++) begin
            v = mrd(o16, a);
            for (int k = dl - 1; k >= 0; k--) sbit(1'b0, 1, v[k], tag);
            a = (a + 1) % (2**alen);
        end
        sel_dn();
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        for (int i = 0; i < 2**AW; i++) model[i] = 16'hFFFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 oe low after reset", {15'd0, dout_oe}, 16'd0);

        // R10 reset contents, R4 dummy then MSB first
        read_seq(1, 0, 1, "R10 reset ones");

        // R8 disabled after reset: write has no effect
        prog_cmd(1, 2'b01, 3, 1, 16'hA5C3, 0, 0, 1);
        read_seq(1, 3, 1, "R8 write while disabled");

        // R2 enable via extended code 11, then write with busy/ready status
        ext_cmd(1, 2'b11, 0, 16'h0);
        prog_cmd(1, 2'b01, 3, 1, 16'hA5C3, 0, 0, 0);
        mwr(1, 3, 16'hA5C3);
        sel_up();
        check("R9 busy low", {15'd0, dout}, 16'd0);
        check("R10 oe high when selected", {15'd0, dout_oe}, 16'd1);
        for (int i = 0; i < 3; i++) sbit(1'b1, 1, 1'b0, "R9 busy ignores clocking");
        repeat (PROG + 30) @(negedge clk);
        check("R9 ready high", {15'd0, dout}, 16'd1);
        sel_dn();
        check("R10 oe low after deselect", {15'd0, dout_oe}, 16'd0);

        // R7 write stores data; R5 continuous read across a word boundary
        read_seq(1, 3, 2, "R5 sequential word read");

        // R5 wrap from the top address
        prog_cmd(1, 2'b01, 15, 1, 16'h0F0F, 0, 0, 1);
        mwr(1, 15, 16'h0F0F);
        read_seq(1, 15, 2, "R5 word wrap");

        // R1 leading zeros before the start bit
        prog_cmd(1, 2'b01, 5, 1, 16'h1357, 0, 1, 1);
        mwr(1, 5, 16'h1357);
        read_seq(1, 5, 1, "R1 leading zeros");

        // R7 erase one word
        prog_cmd(1, 2'b11, 3, 0, 16'h0, 0, 0, 1);
        mwr(1, 3, 16'hFFFF);
        read_seq(1, 3, 1, "R7 erase");

        // R2 write-all (code 01) then erase-all (code 10)
        ext_cmd(1, 2'b01, 1, 16'h2468);
        mall(1, 16'h2468);
        read_seq(1, 9, 1, "R7 write-all");
        read_seq(1, 0, 1, "R7 write-all low end");
        ext_cmd(1, 2'b10, 0, 16'h0);
        mall(1, 16'hFFFF);
        read_seq(1, 9, 1, "R7 erase-all");

        // R3 byte organisation and its mapping onto words
        org16 = 1'b0;
        repeat (4) @(negedge clk);
        prog_cmd(0, 2'b01, 5, 1, 16'h003C, 0, 0, 1);
        mwr(0, 5, 16'h003C);
        read_seq(0, 5, 1, "R3 byte read");
        prog_cmd(0, 2'b01, 31, 1, 16'h00A6, 0, 0, 1);
        mwr(0, 31, 16'h00A6);
        read_seq(0, 31, 2, "R5 byte wrap");
        org16 = 1'b1;
        repeat (4) @(negedge clk);
        read_seq(1, 2, 1, "R3 byte lands in upper half");

        // R6 pulse count: one extra clock, then one bit short
        prog_cmd(1, 2'b01, 6, 1, 16'h1111, 1, 0, 1);
        read_seq(1, 6, 1, "R6 extra clock rejected");
        prog_cmd(1, 2'b01, 6, 1, 16'h1111, -1, 0, 1);
        read_seq(1, 6, 1, "R6 short frame rejected");

        // R8 disable via extended code 00; write ignored, read still works
        ext_cmd(1, 2'b00, 0, 16'h0);
        prog_cmd(1, 2'b01, 6, 1, 16'h2222, 0, 0, 1);
        read_seq(1, 6, 1, "R8 write after disable");
        read_seq(1, 5, 1, "R8 read while disabled");

        repeat (20) @(negedge clk);
        check("R4 scoreboard drained", 16'(exp_q.size()), 16'd0);
        report();
    end
endmodule